// File: doc/BRIEF.md
# Layer-Majority Pattern Matcher

The block keeps a bank of stored track patterns. Each pattern holds one word per detector layer. While an event is read out, hits arrive on one bus per layer. Every pattern compares the hits on all layers against its own stored words at the same time, with a private comparator for each word. When a hit equals the stored word of its layer, the pattern raises a flag for that layer. The flag stays set until the event is cleared, so hits for one pattern may be spread over many cycles and may arrive in any order.

A pattern is declared matched once enough of its layer flags are set. The threshold is a parameter, and it defaults to five of six layers. At the end of the event, a readout operation sends out the indices of the matched patterns. It gives one index per cycle, lowest index first, and reports each pattern at most once. A small opcode field selects the operation for each cycle: search, write a stored word, read a stored word, clear the event, run the readout, or do nothing. The write and read operations take a pattern index and a layer select.

Top module: `pattern_match_bank`

## Requirements
- R1: After reset, match_valid and rd_valid are 0 and every stored word reads back as 0.
- R2: With op_code 2 (write), wr_word is stored as the word of pattern pat_addr for layer plane_sel. With op_code 3 (read), that word appears on rd_word with rd_valid high in the next cycle.
- R3: A plane_sel value of 6 or more makes a write change nothing. A read with such a value returns rd_word 0 with rd_valid high.
- R4: With op_code 1 (search), every pattern whose stored word for layer l equals hit_data[l*12 +: 12] sets its flag for layer l, provided hit_valid[l] is high. Flags are sticky, so hits given in separate cycles add up.
- R5: A hit on a layer whose hit_valid bit is low sets no flag, even when its data equals a stored word.
- R6: A pattern is matched when at least MATCH_MIN (default 5) of its six layer flags are set. With fewer flags it is never reported.
- R7: Each cycle with op_code 5 (readout) reports, in the next cycle, the lowest-index matched pattern not yet reported in this event. The index appears on match_addr with match_valid high. Indices come out in ascending order on consecutive readout cycles, and each pattern is reported at most once per event.
- R8: A readout cycle with no unreported matched pattern gives match_valid 0 in the next cycle.
- R9: op_code 4 (clear) resets all layer flags and the record of reported patterns in one cycle. Stored words are kept.
- R10: Any other op_code (0, 6 to 15) changes nothing. Hits presented with such an opcode set no flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_code | input | 4 | Operation for this cycle |
| pat_addr | input | 7 | Pattern index for write and read |
| plane_sel | input | 3 | Layer select for write and read |
| wr_word | input | 12 | Word to store |
| hit_data | input | 72 | Six hit words, layer l at bits l*12 +: 12 |
| hit_valid | input | 6 | Per-layer hit qualifier |
| rd_word | output | 12 | Word read back |
| rd_valid | output | 1 | rd_word holds a read result |
| match_addr | output | 7 | Index of a reported matched pattern |
| match_valid | output | 1 | match_addr holds a report |

## Verification
The bench covers several corner cases. Hits for one pattern are split over several search cycles. If flags were not sticky, such a pattern would never be reported. A pattern is left at one flag below the threshold and must stay silent; an off-by-one threshold would report it. Hit lanes whose valid bit is low carry matching data, which catches a comparator that ignores the qualifier. Hits are also presented with non-search opcodes, which must not set flags.

Two patterns with identical words must come out on consecutive cycles in ascending order. Repeated readouts must not report a pattern twice. A clear followed by a partial re-hit shows whether flags from before the clear are still there. Reads after the clear and after a write with an out-of-range layer show whether storage was disturbed.

// File: rtl/am_pkg.sv
// Shared opcode encoding for the pattern matcher.
// Assumes a 4-bit opcode field sampled every cycle.
package am_pkg;

    localparam int unsigned OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_IDLE    = 4'h0,
        OP_SEARCH  = 4'h1,
        OP_WRITE   = 4'h2,
        OP_READ    = 4'h3,
        OP_CLEAR   = 4'h4,
        OP_READOUT = 4'h5
    } am_op_e;

endpackage

// File: rtl/pm_slot.sv
// One stored pattern: a word per layer, a comparator per word, a sticky
// flag per layer and the majority decision. Assumes at most one write
// per cycle and that clear and search are never asserted together.
module pm_slot #(
    parameter int LAYERS    = 6,
    parameter int WORD_W    = 12,
    parameter int MATCH_MIN = 5,
    localparam int SEL_W    = $clog2(LAYERS),
    localparam int CNT_W    = $clog2(LAYERS + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [SEL_W-1:0]         wr_layer,
    input  logic [WORD_W-1:0]        wr_word,
    input  logic                     search_en,
    input  logic                     clear_en,
    input  logic [LAYERS*WORD_W-1:0] hit_data,
    input  logic [LAYERS-1:0]        hit_valid,
    output logic [LAYERS*WORD_W-1:0] word_out,
    output logic                     matched
);

    logic [LAYERS-1:0] flags;
    logic [CNT_W-1:0]  flag_cnt;

    for (genvar l = 0; l < LAYERS; l++) begin : g_layer
        logic [WORD_W-1:0] stored;
        logic              flag;
        logic              hit_eq;

        // Private comparator: qualified hit equals this layer's word.
        assign hit_eq = hit_valid[l] && (hit_data[l*WORD_W +: WORD_W] == stored);

        // Layer word storage, loaded only when this layer is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stored <= '0;
            end else if (wr_en && (wr_layer == SEL_W'(l))) begin
                stored <= wr_word;
            end
        end

        // Sticky layer flag, set by a search hit and dropped by clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag <= 1'b0;
            end else if (clear_en) begin
                flag <= 1'b0;
            end else if (search_en && hit_eq) begin
                flag <= 1'b1;
            end
        end

        assign word_out[l*WORD_W +: WORD_W] = stored;
        assign flags[l] = flag;
    end

    // Count set layer flags for the majority decision.
    always_comb begin
        flag_cnt = '0;
        for (int l = 0; l < LAYERS; l++) begin
            flag_cnt = flag_cnt + CNT_W'(flags[l]);
        end
    end

    assign matched = (int'(flag_cnt) >= MATCH_MIN);

endmodule

// File: rtl/pm_first_set.sv
// Priority encoder: index of the lowest set request bit.
// Assumes idx is meaningful only when found is high.
module pm_first_set #(
    parameter int N  = 128,
    localparam int AW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic [AW-1:0] idx,
    output logic          found
);

    // Scan from the top so the lowest set bit wins last.
    always_comb begin
        idx   = '0;
        found = |req;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = AW'(i);
            end
        end
    end

endmodule

// File: rtl/pm_readout.sv
// End-of-event readout: reports one unreported matched pattern per
// readout cycle, lowest index first, and remembers what it reported.
// Assumes matched is stable while readout runs.
module pm_readout #(
    parameter int N  = 128,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  matched,
    input  logic          clear_en,
    input  logic          readout_en,
    output logic [AW-1:0] match_addr,
    output logic          match_valid
);

    logic [N-1:0]  taken;
    logic [N-1:0]  pending;
    logic [AW-1:0] first_idx;
    logic          any_pending;

    assign pending = matched & ~taken;

    pm_first_set #(.N(N)) u_first (
        .req   (pending),
        .idx   (first_idx),
        .found (any_pending)
    );

    // Mark the reported pattern; a clear starts a new event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taken <= '0;
        end else if (clear_en) begin
            taken <= '0;
        end else if (readout_en && any_pending) begin
            taken[first_idx] <= 1'b1;
        end
    end

    // Registered report outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_valid <= 1'b0;
            match_addr  <= '0;
        end else begin
            match_valid <= readout_en && any_pending;
            if (readout_en && any_pending) begin
                match_addr <= first_idx;
            end
        end
    end

endmodule

// File: rtl/pattern_match_bank.sv
// Bank of stored patterns searched in parallel by per-layer hit buses,
// with majority matching and an ordered readout of matched indices.
// Assumes one opcode per cycle; hits are used only with the search code.
module pattern_match_bank #(
    parameter int NUM_PATTERNS = 128,
    parameter int LAYERS       = 6,
    parameter int WORD_W       = 12,
    parameter int MATCH_MIN    = 5,
    localparam int ADDR_W      = $clog2(NUM_PATTERNS),
    localparam int SEL_W       = $clog2(LAYERS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [3:0]               op_code,
    input  logic [ADDR_W-1:0]        pat_addr,
    input  logic [SEL_W-1:0]         plane_sel,
    input  logic [WORD_W-1:0]        wr_word,
    input  logic [LAYERS*WORD_W-1:0] hit_data,
    input  logic [LAYERS-1:0]        hit_valid,
    output logic [WORD_W-1:0]        rd_word,
    output logic                     rd_valid,
    output logic [ADDR_W-1:0]        match_addr,
    output logic                     match_valid
);
    import am_pkg::*;

    logic search_en;
    logic write_en;
    logic read_en;
    logic clear_en;
    logic readout_en;

    // Opcode decode into one strobe per operation.
    assign search_en  = (op_code == OP_SEARCH);
    assign write_en   = (op_code == OP_WRITE);
    assign read_en    = (op_code == OP_READ);
    assign clear_en   = (op_code == OP_CLEAR);
    assign readout_en = (op_code == OP_READOUT);

    logic [NUM_PATTERNS-1:0]  matched;
    logic [LAYERS*WORD_W-1:0] words [NUM_PATTERNS];

    for (genvar p = 0; p < NUM_PATTERNS; p++) begin : g_slot
        pm_slot #(
            .LAYERS    (LAYERS),
            .WORD_W    (WORD_W),
            .MATCH_MIN (MATCH_MIN)
        ) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (write_en && (pat_addr == ADDR_W'(p))),
            .wr_layer  (plane_sel),
            .wr_word   (wr_word),
            .search_en (search_en),
            .clear_en  (clear_en),
            .hit_data  (hit_data),
            .hit_valid (hit_valid),
            .word_out  (words[p]),
            .matched   (matched[p])
        );
    end

    pm_readout #(.N(NUM_PATTERNS)) u_readout (
        .clk         (clk),
        .rst_n       (rst_n),
        .matched     (matched),
        .clear_en    (clear_en),
        .readout_en  (readout_en),
        .match_addr  (match_addr),
        .match_valid (match_valid)
    );

    logic [LAYERS*WORD_W-1:0] read_row;
    logic [WORD_W-1:0]        read_sel;

    // Select the addressed word; out-of-range layer or pattern gives zero.
    always_comb begin
        read_row = '0;
        read_sel = '0;
        if (int'(pat_addr) < NUM_PATTERNS) begin
            read_row = words[pat_addr];
        end
        for (int l = 0; l < LAYERS; l++) begin
            if (int'(plane_sel) == l) begin
                read_sel = read_row[l*WORD_W +: WORD_W];
            end
        end
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_word  <= '0;
        end else begin
            rd_valid <= read_en;
            if (read_en) begin
                rd_word <= read_sel;
            end
        end
    end

endmodule

// File: rtl/pm_checker.sv
// Protocol checks on the matcher's ports, bound to the top module.
// Assumes rst_n is synchronous and active low.
module pm_checker #(
    parameter int ADDR_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        op_code,
    input logic              rd_valid,
    input logic              match_valid,
    input logic [ADDR_W-1:0] match_addr
);
    import am_pkg::*;

    // A report only follows a readout cycle.
    assert_report_after_readout_R7: assert property (@(posedge clk) disable iff (!rst_n)
        match_valid |-> ($past(op_code) == OP_READOUT));

    // Back-to-back reports are strictly ascending.
    assert_ascending_reports_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (match_valid && $past(match_valid)) |-> (match_addr > $past(match_addr)));

    // Readout right after a clear finds nothing.
    assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(op_code) == OP_CLEAR) && (op_code == OP_READOUT)) |=> !match_valid);

    // Read data is only flagged after a read.
    assert_read_after_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(op_code) == OP_READ));

    // A write produces neither read data nor a report.
    assert_write_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == OP_WRITE) |=> (!match_valid && !rd_valid));

endmodule

bind pattern_match_bank pm_checker #(.ADDR_W(ADDR_W)) u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_code     (op_code),
    .rd_valid    (rd_valid),
    .match_valid (match_valid),
    .match_addr  (match_addr)
);

// File: tb/tb_pattern_match_bank.sv
// Scoreboard bench: a model of the requirements queues expected indices,
// a monitor pops and compares each reported index.
module tb_pattern_match_bank;
    import am_pkg::*;

    localparam int NP = 128;
    localparam int NL = 6;
    localparam int WW = 12;
    localparam int MM = 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [3:0]      op_code = OP_IDLE;
    logic [6:0]      pat_addr = '0;
    logic [2:0]      plane_sel = '0;
    logic [WW-1:0]   wr_word = '0;
    logic [NL*WW-1:0] hit_data = '0;
    logic [NL-1:0]   hit_valid = '0;
    logic [WW-1:0]   rd_word;
    logic            rd_valid;
    logic [6:0]      match_addr;
    logic            match_valid;

    always #2 clk = ~clk;

    pattern_match_bank dut (
        .clk(clk), .rst_n(rst_n), .op_code(op_code), .pat_addr(pat_addr),
        .plane_sel(plane_sel), .wr_word(wr_word), .hit_data(hit_data),
        .hit_valid(hit_valid), .rd_word(rd_word), .rd_valid(rd_valid),
        .match_addr(match_addr), .match_valid(match_valid)
    );

    int    checks = 0;
    int    errors = 0;
    string cur_tag = "R7";
    int    exp_q[$];

    logic [WW-1:0] m_word [NP][NL];
    bit            m_flag [NP][NL];
    bit            m_rep  [NP];

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int fval(input int p, input int l);
        return (p + 1) * 16 + l + 1;
    endfunction

    // Monitor: compare every report against the scoreboard queue.
    always @(posedge clk) begin
        #1;
        if (rst_n && match_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, cur_tag, "unexpected report addr", int'(match_addr), -1);
            end else begin
                int e;
                e = exp_q.pop_front();
                chk(int'(match_addr) == e, cur_tag, "report addr", int'(match_addr), e);
            end
        end
    end

    task automatic t_idle();
        @(negedge clk);
        op_code = OP_IDLE;
        hit_valid = '0;
    endtask

    task automatic t_write(input int p, input int l, input int v);
        @(negedge clk);
        op_code = OP_WRITE; pat_addr = 7'(p); plane_sel = 3'(l); wr_word = WW'(v);
        if (l < NL) m_word[p][l] = WW'(v);
    endtask

    task automatic t_read(input int p, input int l, input string tag);
        int e;
        e = (l < NL) ? int'(m_word[p][l]) : 0;
        @(negedge clk);
        op_code = OP_READ; pat_addr = 7'(p); plane_sel = 3'(l);
        @(posedge clk); #1;
        chk(rd_valid == 1'b1, tag, "rd_valid", int'(rd_valid), 1);
        chk(int'(rd_word) == e, tag, "rd_word", int'(rd_word), e);
    endtask

    task automatic t_hits(input logic [3:0] op, input int hv[NL], input logic [NL-1:0] vld);
        @(negedge clk);
        op_code = op;
        hit_valid = vld;
        for (int l = 0; l < NL; l++) hit_data[l*WW +: WW] = WW'(hv[l]);
        if (op == OP_SEARCH) begin
            for (int p = 0; p < NP; p++)
                for (int l = 0; l < NL; l++)
                    if (vld[l] && (WW'(hv[l]) == m_word[p][l])) m_flag[p][l] = 1'b1;
        end
    endtask

    task automatic t_pattern_hits(input int p, input logic [NL-1:0] vld);
        int hv[NL];
        for (int l = 0; l < NL; l++) hv[l] = fval(p, l);
        t_hits(OP_SEARCH, hv, vld);
    endtask

    task automatic t_clear();
        @(negedge clk);
        op_code = OP_CLEAR;
        hit_valid = '0;
        for (int p = 0; p < NP; p++) begin
            m_rep[p] = 1'b0;
            for (int l = 0; l < NL; l++) m_flag[p][l] = 1'b0;
        end
    endtask

    // Driver: queue expected indices, then run one extra readout cycle.
    task automatic t_readout(input string tag);
        int n = 0;
        cur_tag = tag;
        for (int p = 0; p < NP; p++) begin
            int c = 0;
            for (int l = 0; l < NL; l++) c += int'(m_flag[p][l]);
            if (c >= MM && !m_rep[p]) begin
                exp_q.push_back(p);
                m_rep[p] = 1'b1;
                n++;
            end
        end
        for (int k = 0; k <= n; k++) begin
            @(negedge clk);
            op_code = OP_READOUT;
            hit_valid = '0;
        end
        t_idle();
        @(posedge clk); #2;
        chk(exp_q.size() == 0, tag, "reports missing", exp_q.size(), 0);
        exp_q.delete();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R7 actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int junk[NL];
        for (int p = 0; p < NP; p++) begin
            m_rep[p] = 1'b0;
            for (int l = 0; l < NL; l++) begin
                m_word[p][l] = '0;
                m_flag[p][l] = 1'b0;
            end
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        // R1: reset state
        chk(match_valid == 1'b0, "R1", "match_valid", int'(match_valid), 0);
        chk(rd_valid == 1'b0, "R1", "rd_valid", int'(rd_valid), 0);
        t_read(0, 0, "R1");
        t_read(127, 5, "R1");

        // R2: load patterns, patterns 20 and 21 identical
        foreach (m_rep[p]) begin
            if (p == 0 || p == 3 || p == 10 || p == 20 || p == 77 || p == 127)
                for (int l = 0; l < NL; l++) t_write(p, l, fval(p, l));
        end
        for (int l = 0; l < NL; l++) t_write(21, l, fval(20, l));
        t_read(10, 4, "R2");
        t_read(127, 5, "R2");
        t_read(21, 2, "R2");

        // R3: out-of-range layer
        t_write(3, 7, 12'hABC);
        t_write(3, 6, 12'hDEF);
        t_read(3, 7, "R3");
        for (int l = 0; l < NL; l++) t_read(3, l, "R3");

        // R4/R5/R6: split hits, below-threshold, invalid lanes
        t_pattern_hits(3, 6'b000111);
        t_pattern_hits(3, 6'b011000);
        t_pattern_hits(10, 6'b001111);
        t_pattern_hits(77, 6'b001111);
        t_pattern_hits(127, 6'b111110);
        t_readout("R6");
        t_readout("R8");

        // R4: sticky flags complete pattern 10 later
        t_pattern_hits(10, 6'b100000);
        t_readout("R4");

        // R10: hits with non-search opcodes
        for (int l = 0; l < NL; l++) junk[l] = fval(77, l);
        t_hits(OP_IDLE, junk, 6'b110000);
        t_hits(4'h7, junk, 6'b110000);
        t_hits(4'hF, junk, 6'b110000);
        t_readout("R10");

        // R7: two identical patterns reported back to back
        t_pattern_hits(20, 6'b111111);
        t_readout("R7");
        t_readout("R7");

        // R9: clear keeps words, drops flags and report record
        t_clear();
        t_readout("R9");
        t_read(3, 2, "R9");
        t_pattern_hits(77, 6'b000111);
        t_readout("R9");
        t_pattern_hits(77, 6'b011000);
        t_readout("R9");
        t_pattern_hits(3, 6'b111111);
        t_readout("R9");

        t_idle();
        repeat (3) @(posedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule